// File: doc/BRIEF.md
# Serial Command Video Source Selector

This block listens on a single asynchronous serial line and turns the incoming byte stream into 32-bit command words. Every fourth good byte completes a word, which is announced with a one-cycle strobe. The last completed word is kept in a command register. Decode logic reads that register and drives a source choice plus the frame width and height that go with it. Downstream, a frame-buffer write multiplexer and a video timing generator use these outputs.

Two command words have a meaning. One selects the HDMI input at 1920x1080. The other selects the camera input at 1280x720. Any other value, including the all-zero value left by reset, falls back to the HDMI input at 1920x1080.

The receiver oversamples the line with the system clock and samples each bit at its middle. Two kinds of trouble discard a partly assembled word: a silence between bytes longer than a set number of character times, and a byte whose stop bit is low.

Top module: `cmd_src_select`

## Requirements
- R1: After reset the command register holds zero, so `src_cam` is 0 and the outputs read 1920x1080. `word_done` is low.
- R2: The line format is 8N1 with the least significant bit first. The bit period is round(CLK_HZ/BAUD) clock cycles, and each bit is sampled at its middle.
- R3: Four received bytes form one word, with the first byte in bits [31:24]. `word_done` is high for exactly one cycle and carries the word on `word_data`.
- R4: Command word 0x0000AABB gives `src_cam`=0 (HDMI source) with width 1920 and height 1080.
- R5: Command word 0x0000CCDD gives `src_cam`=1 (camera source) with width 1280 and height 720.
- R6: Any other completed word gives `src_cam`=0 with 1920x1080, even when the camera was selected before.
- R7: The outputs change only in the cycle after a `word_done` pulse. Partly received words leave the outputs unchanged.
- R8: A gap of more than GAP_CHARS character times (10 bit periods each) after a byte of an unfinished word discards that partial word. The next byte then starts a new word.
- R9: A byte whose stop bit samples low is dropped and the partial word is discarded. After such an error, reception resumes only once the line has returned high.
- R10: A low pulse shorter than half a bit period on an idle line is not taken as a start bit and produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_rx | input | 1 | Serial receive line, idle high |
| word_done | output | 1 | One-cycle pulse when a 32-bit word completes |
| word_data | output | 32 | Last completed word, valid while `word_done` is high |
| src_cam | output | 1 | 1 selects the camera input, 0 selects the HDMI input |
| frame_w | output | 12 | Active frame width for the selected source |
| frame_h | output | 12 | Active frame height for the selected source |

## Verification
The hardest states to reach from the ports are the two recovery paths. Both leave a partial word that must be thrown away, and an error in either one only shows up as a wrong decode several bytes later.
The stimulus handles this by sending two leading zero bytes and then either stalling the line past the gap limit or sending a byte with a low stop bit. It follows with a complete camera command word.
If the partial word were kept, the first four bytes received would form an all-zero word, and the outputs would show HDMI instead of the camera.
A separate sub-half-bit low glitch on the idle line shows that the start-bit check does not produce false bytes.

// File: rtl/cmd_sel_pkg.sv
package cmd_sel_pkg;

    localparam logic [31:0] CMD_HDMI = 32'h0000_AABB;
    localparam logic [31:0] CMD_CAM  = 32'h0000_CCDD;

    localparam int DIM_W = 12;

    localparam logic [DIM_W-1:0] HDMI_W = 12'd1920;
    localparam logic [DIM_W-1:0] HDMI_H = 12'd1080;
    localparam logic [DIM_W-1:0] CAM_W  = 12'd1280;
    localparam logic [DIM_W-1:0] CAM_H  = 12'd720;

    typedef enum logic {
        SRC_HDMI = 1'b0,
        SRC_CAM  = 1'b1
    } src_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;

endpackage

// File: rtl/cmd_uart_rx.sv
module cmd_uart_rx
    import cmd_sel_pkg::*;
#(
    parameter int CLK_HZ = 200_000_000,
    parameter int BAUD   = 115_200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_async,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       frame_err
);
    localparam int DIV   = (CLK_HZ + BAUD / 2) / BAUD;
    localparam int HALF  = DIV / 2;
    localparam int DIV_W = $clog2(DIV + 1);

    typedef struct packed {
        logic [1:0]       sync;
        rx_state_e        state;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       bitn;
        logic [7:0]       shreg;
        logic             vld;
        logic             err;
    } rx_t;

    rx_t s_d, s_q;
    logic rx_s;

    assign rx_s = s_q.sync[1];

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], rx_async};
        s_d.vld  = 1'b0;
        s_d.err  = 1'b0;
        unique case (s_q.state)
            RX_IDLE: begin
                s_d.cnt = '0;
                if (!rx_s) s_d.state = RX_START;
            end
            RX_START: begin
                if (s_q.cnt == DIV_W'(HALF - 1)) begin
                    s_d.cnt  = '0;
                    s_d.bitn = '0;
                    s_d.state = rx_s ? RX_IDLE : RX_DATA;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                if (s_q.cnt == DIV_W'(DIV - 1)) begin
                    s_d.cnt   = '0;
                    s_d.shreg = {rx_s, s_q.shreg[7:1]};
                    if (s_q.bitn == 3'd7) s_d.state = RX_STOP;
                    else                  s_d.bitn  = s_q.bitn + 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (s_q.cnt == DIV_W'(DIV - 1)) begin
                    s_d.cnt = '0;
                    if (rx_s) begin
                        s_d.vld   = 1'b1;
                        s_d.state = RX_IDLE;
                    end else begin
                        s_d.err   = 1'b1;
                        s_d.state = RX_BREAK;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RX_BREAK: begin
                if (rx_s) s_d.state = RX_IDLE;
            end
            default: s_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.sync  <= 2'b11;
            s_q.state <= RX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_vld  = s_q.vld;
    assign byte_data = s_q.shreg;
    assign frame_err = s_q.err;

endmodule

// File: rtl/cmd_word_packer.sv
module cmd_word_packer #(
    parameter int GAP_CYCLES = 34_720
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic [7:0]  byte_data,
    input  logic        frame_err,
    output logic        done,
    output logic [31:0] data
);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);

    typedef struct packed {
        logic [1:0]       cnt;
        logic [31:0]      word;
        logic [GAP_W-1:0] gap;
        logic             done;
        logic [31:0]      data;
    } pk_t;

    pk_t p_d, p_q;
    logic [31:0] shifted;

    assign shifted = {p_q.word[23:0], byte_data};

    always_comb begin
        p_d      = p_q;
        p_d.done = 1'b0;
        if (frame_err) begin
            p_d.cnt = '0;
            p_d.gap = '0;
        end else if (byte_vld) begin
            p_d.word = shifted;
            p_d.gap  = '0;
            if (p_q.cnt == 2'd3) begin
                p_d.done = 1'b1;
                p_d.data = shifted;
                p_d.cnt  = '0;
            end else begin
                p_d.cnt = p_q.cnt + 1'b1;
            end
        end else if (p_q.cnt != '0) begin
            if (p_q.gap == GAP_W'(GAP_CYCLES - 1)) begin
                p_d.cnt = '0;
                p_d.gap = '0;
            end else begin
                p_d.gap = p_q.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign done = p_q.done;
    assign data = p_q.data;

endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
    import cmd_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [31:0]      word,
    output logic             src_cam,
    output logic [DIM_W-1:0] width,
    output logic [DIM_W-1:0] height
);
    typedef struct packed {
        logic [31:0] cmd;
    } dec_t;

    dec_t c_d, c_q;
    src_e src;

    always_comb begin
        c_d = c_q;
        if (load) c_d.cmd = word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        if (c_q.cmd == CMD_CAM) begin
            src    = SRC_CAM;
            width  = CAM_W;
            height = CAM_H;
        end else begin
            src    = SRC_HDMI;
            width  = HDMI_W;
            height = HDMI_H;
        end
    end

    assign src_cam = (src == SRC_CAM);

endmodule

// File: rtl/cmd_src_select.sv
module cmd_src_select
    import cmd_sel_pkg::*;
#(
    parameter int CLK_HZ    = 200_000_000,
    parameter int BAUD      = 115_200,
    parameter int GAP_CHARS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uart_rx,
    output logic             word_done,
    output logic [31:0]      word_data,
    output logic             src_cam,
    output logic [DIM_W-1:0] frame_w,
    output logic [DIM_W-1:0] frame_h
);
    localparam int DIV        = (CLK_HZ + BAUD / 2) / BAUD;
    localparam int GAP_CYCLES = GAP_CHARS * 10 * DIV;

    logic       byte_vld;
    logic [7:0] byte_data;
    logic       frame_err;

    cmd_uart_rx #(
        .CLK_HZ (CLK_HZ),
        .BAUD   (BAUD)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_async  (uart_rx),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .frame_err (frame_err)
    );

    cmd_word_packer #(
        .GAP_CYCLES (GAP_CYCLES)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .frame_err (frame_err),
        .done      (word_done),
        .data      (word_data)
    );

    cmd_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (word_done),
        .word    (word_data),
        .src_cam (src_cam),
        .width   (frame_w),
        .height  (frame_h)
    );

endmodule

// File: rtl/cmd_src_select_checker.sv
module cmd_src_select_checker
    import cmd_sel_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             word_done,
    input logic [31:0]      word_data,
    input logic             src_cam,
    input logic [DIM_W-1:0] frame_w,
    input logic [DIM_W-1:0] frame_h
);
    // R3: the word strobe never lasts two cycles
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

    // R4
    assert_hdmi_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && word_data == CMD_HDMI) |=> (!src_cam && frame_w == HDMI_W && frame_h == HDMI_H));

    // R5
    assert_cam_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && word_data == CMD_CAM) |=> (src_cam && frame_w == CAM_W && frame_h == CAM_H));

    // R6
    assert_other_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && word_data != CMD_CAM) |=> (!src_cam && frame_w == HDMI_W && frame_h == HDMI_H));

    // R7: outputs move only right after a completed word
    assert_change_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(src_cam) || !$stable(frame_w) || !$stable(frame_h)) |-> $past(word_done));

endmodule

bind cmd_src_select cmd_src_select_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_done (word_done),
    .word_data (word_data),
    .src_cam   (src_cam),
    .frame_w   (frame_w),
    .frame_h   (frame_h)
);

// File: tb/cmd_src_select_bench.sv
`timescale 1ns/1ps
module cmd_src_select_bench;
    localparam int CLK_HZ = 1_600_000;
    localparam int BAUD   = 100_000;
    localparam int DIV    = 16;
    localparam int GAPC   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uart_rx = 1'b1;
    logic        word_done;
    logic [31:0] word_data;
    logic        src_cam;
    logic [11:0] frame_w, frame_h;

    int tests = 0;
    int fails = 0;
    int done_cnt = 0;
    int pulse_bad = 0;
    logic [31:0] last_word = '0;
    logic prev_done = 1'b0;

    always #2 clk = ~clk;

    cmd_src_select #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .GAP_CHARS(GAPC)) u_cmd_src_select (
        .clk(clk), .rst_n(rst_n), .uart_rx(uart_rx),
        .word_done(word_done), .word_data(word_data),
        .src_cam(src_cam), .frame_w(frame_w), .frame_h(frame_h)
    );

    always @(negedge clk) begin
        if (word_done) begin
            done_cnt++;
            last_word = word_data;
        end
        if (word_done && prev_done) pulse_bad++;
        prev_done = word_done;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop);
        uart_rx = 1'b0; idle(DIV);
        for (int i = 0; i < 8; i++) begin
            uart_rx = b[i]; idle(DIV);
        end
        uart_rx = stop; idle(DIV);
        uart_rx = 1'b1; idle(2);
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int k = 3; k >= 0; k--) send_byte(w[k*8 +: 8], 1'b1);
        idle(4);
    endtask

    task automatic expect_src(input string req, input logic cam);
        check(req, {31'd0, src_cam}, {31'd0, cam});
        check(req, {20'd0, frame_w}, cam ? 32'd1280 : 32'd1920);
        check(req, {20'd0, frame_h}, cam ? 32'd720 : 32'd1080);
    endtask

    task automatic t_reset;
        idle(3);
        expect_src("R1", 1'b0);
        check("R1 word_done", {31'd0, word_done}, 32'd0);
    endtask

    task automatic t_camera;
        int n0 = done_cnt;
        send_word(32'h0000CCDD);
        check("R3 count", done_cnt - n0, 1);
        check("R2 R3 data", last_word, 32'h0000CCDD);
        expect_src("R5", 1'b1);
    endtask

    task automatic t_hdmi;
        send_word(32'h0000AABB);
        check("R4 data", last_word, 32'h0000AABB);
        expect_src("R4", 1'b0);
    endtask

    task automatic t_unknown;
        send_word(32'h0000CCDD);
        expect_src("R5 setup", 1'b1);
        send_word(32'h5A3C96E1);
        check("R2 R3 order", last_word, 32'h5A3C96E1);
        expect_src("R6", 1'b0);
    endtask

    task automatic t_hold;
        int n0;
        send_word(32'h0000CCDD);
        n0 = done_cnt;
        send_byte(8'h00, 1'b1);
        send_byte(8'h00, 1'b1);
        check("R7 no word", done_cnt - n0, 0);
        expect_src("R7", 1'b1);
        idle(GAPC * 10 * DIV + 40);
    endtask

    task automatic t_gap;
        send_word(32'h0000AABB);
        send_byte(8'h00, 1'b1);
        send_byte(8'h00, 1'b1);
        idle(GAPC * 10 * DIV + 40);
        send_word(32'h0000CCDD);
        check("R8 data", last_word, 32'h0000CCDD);
        expect_src("R8", 1'b1);
    endtask

    task automatic t_framing;
        int n0;
        send_word(32'h0000AABB);
        n0 = done_cnt;
        send_byte(8'h00, 1'b1);
        send_byte(8'h00, 1'b1);
        send_byte(8'hCC, 1'b0);
        send_word(32'h0000CCDD);
        check("R9 count", done_cnt - n0, 1);
        check("R9 data", last_word, 32'h0000CCDD);
        expect_src("R9", 1'b1);
    endtask

    task automatic t_glitch;
        int n0;
        send_word(32'h0000AABB);
        n0 = done_cnt;
        for (int g = 0; g < 4; g++) begin
            uart_rx = 1'b0; idle(DIV / 2 - 4);
            uart_rx = 1'b1; idle(2 * DIV);
        end
        send_word(32'h0000CCDD);
        check("R10 count", done_cnt - n0, 1);
        check("R10 data", last_word, 32'h0000CCDD);
        expect_src("R10", 1'b1);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        t_reset();
        t_camera();
        t_hdmi();
        t_unknown();
        t_hold();
        t_gap();
        t_framing();
        t_glitch();
        check("R3 pulse width", pulse_bad, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule